// File: doc/BRIEF.md
# Font ROM Self-Test Sequencer

This block runs the built-in self-test of a dot-matrix character display controller. A one-cycle start strobe, raised by the bus logic when software writes the self-test bit of the control word, launches a routine with a fixed length. First the sequencer reads every column byte of every glyph in the font ROM and keeps a modulo-256 sum of the bytes. It then compares that sum with a constant set at build time and records pass or fail. Next it takes over the pixel stream to the LED scanner and shows a checkerboard, followed by its inverse, for a fixed number of clocks each.

In the last cycles of the routine the sequencer puts the display memories into a known state. It writes one location per cycle over a shared write port. The digit memory is filled with the blank code, the per-digit flash bits are cleared, the glyph-address register is set to all ones, and the control word is written with only the result bit. The `busy_o` flag stays high for the whole routine. The surrounding bus logic blocks processor access while it is high.

Top module: `fst_selftest`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `rom_rd_o`, `pat_en_o`, `pat_pixel_o` and `wr_en_o` are all 0 until a start is accepted.
- R2: A high `start_i` at a clock edge while idle makes `busy_o` high from that edge on, for exactly `TOTAL_CLKS` cycles. Busy cycles are numbered k = 0 .. TOTAL_CLKS-1.
- R3: `start_i` has no effect while `busy_o` is high. The routine is neither restarted nor lengthened. A start held high over the last busy cycle begins a new routine right after it.
- R4: In busy cycles k < ROM_CHARS*ROM_COLS, `rom_rd_o` is 1 and the ROM address is glyph = k / ROM_COLS and column = k mod ROM_COLS (column varies fastest). In all other cycles `rom_rd_o` is 0. The ROM returns the byte for an address on `rom_data_i` one cycle later.
- R5: The result is pass exactly when the modulo-256 sum of all returned ROM bytes equals `EXP_SUM`.
- R6: Let P = TOTAL_CLKS - 2*PAT_CLKS - (2*DIGITS+2). In busy cycles P <= k < P+PAT_CLKS, `pat_en_o` is 1 and `pat_pixel_o` is 1 exactly when `scan_row_i + scan_col_i` is even.
- R7: In busy cycles P+PAT_CLKS <= k < P+2*PAT_CLKS, `pat_en_o` is 1 and `pat_pixel_o` is 1 exactly when `scan_row_i + scan_col_i` is odd.
- R8: In the last 2*DIGITS+2 busy cycles, `wr_en_o` is 1 with one write per cycle, in this order:
  - target 0 (digit memory), addresses 0 .. DIGITS-1, data 20h;
  - target 1 (flash bits), addresses 0 .. DIGITS-1, data 0;
  - target 2 (glyph-address register), address 0, data with the low GLYPH_W bits set;
  - target 3 (control word), address 0.
- R9: The control word write has only bit 5 possibly set, and bit 5 is 1 for pass and 0 for fail.
- R10: Outside the windows of R6 and R7, `pat_en_o` and `pat_pixel_o` are 0. Outside the window of R8, `wr_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Self-test start strobe from the control-word decode |
| busy_o | output | 1 | Routine in progress; bus access must be held off |
| rom_rd_o | output | 1 | ROM read request for the address below |
| rom_char_o | output | $clog2(ROM_CHARS) | Glyph index to the font ROM |
| rom_col_o | output | $clog2(ROM_COLS) | Column index within the glyph |
| rom_data_i | input | 8 | ROM column byte, one cycle after the address |
| scan_row_i | input | SCAN_W | Row the scanner is currently driving |
| scan_col_i | input | SCAN_W | Column the scanner is currently driving |
| pat_en_o | output | 1 | Pixel override active |
| pat_pixel_o | output | 1 | Override pixel value for the scanned dot |
| wr_en_o | output | 1 | Restore write strobe |
| wr_tgt_o | output | 2 | Restore target: 0 digit memory, 1 flash bits, 2 glyph address, 3 control word |
| wr_addr_o | output | $clog2(DIGITS) | Digit index of the restore write |
| wr_data_o | output | 8 | Restore write data |

## Verification
The fail path is the hardest case to reach. It needs a ROM whose sum differs from the built-in constant, and the only place the outcome shows is one bit of one write in the last busy cycle. The bench's ROM model can flip one bit of a single glyph byte between runs, so the same parameters give both a pass run and a fail run. A third run holds start high across the whole routine and its final cycle. This shows that start is ignored mid-run and taken up at once after it. The routine is shortened by parameter so all three runs fit in a few thousand cycles.

// File: rtl/fst_pkg.sv
package fst_pkg;
    typedef enum logic [1:0] {
        TGT_CHAR  = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_GLYPH = 2'd2,
        TGT_CTRL  = 2'd3
    } wr_tgt_e;

    typedef enum logic [1:0] {
        PAT_OFF    = 2'd0,
        PAT_CHECK  = 2'd1,
        PAT_INVERT = 2'd2
    } pat_mode_e;
endpackage

// File: rtl/fst_timer.sv
module fst_timer
    import fst_pkg::*;
#(
    parameter int TOTAL_CLKS  = 262144,
    parameter int ROM_SPAN    = 640,
    parameter int PAT_CLKS    = 65536,
    parameter int RESTORE_LEN = 18,
    localparam int CW = $clog2(TOTAL_CLKS)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    output logic      busy_o,
    output logic      rom_phase_o,
    output pat_mode_e pat_mode_o,
    output logic      rest_go_o
);
    localparam int PAT_START  = TOTAL_CLKS - 2 * PAT_CLKS - RESTORE_LEN;
    localparam int REST_START = TOTAL_CLKS - RESTORE_LEN;
    localparam logic [CW-1:0] LAST_C = CW'(TOTAL_CLKS - 1);
    localparam logic [CW-1:0] ROM_C  = CW'(ROM_SPAN);
    localparam logic [CW-1:0] CHK_C  = CW'(PAT_START);
    localparam logic [CW-1:0] INV_C  = CW'(PAT_START + PAT_CLKS);
    localparam logic [CW-1:0] REST_C = CW'(REST_START);
    localparam logic [CW-1:0] GO_C   = CW'(REST_START - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
            end
        end else if (s_q.cnt == LAST_C) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        busy_o      = s_q.busy;
        rom_phase_o = s_q.busy && (s_q.cnt < ROM_C);
        rest_go_o   = s_q.busy && (s_q.cnt == GO_C);
        pat_mode_o  = PAT_OFF;
        if (s_q.busy && s_q.cnt >= CHK_C && s_q.cnt < INV_C)
            pat_mode_o = PAT_CHECK;
        else if (s_q.busy && s_q.cnt >= INV_C && s_q.cnt < REST_C)
            pat_mode_o = PAT_INVERT;
    end

    AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && s_q.cnt != LAST_C |=> s_q.busy && s_q.cnt == CW'($past(s_q.cnt) + 1'b1)); // R2
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && s_q.cnt == LAST_C |=> !s_q.busy); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && start_i && s_q.cnt != LAST_C |=> s_q.cnt != '0); // R3
endmodule

// File: rtl/fst_rom_scan.sv
module fst_rom_scan #(
    parameter int ROM_CHARS = 128,
    parameter int ROM_COLS  = 5,
    parameter int DATA_W    = 8,
    parameter logic [DATA_W-1:0] EXP_SUM = '0,
    localparam int CHW  = $clog2(ROM_CHARS),
    localparam int COLW = $clog2(ROM_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              rom_phase_i,
    input  logic [DATA_W-1:0] rom_data_i,
    output logic              rom_rd_o,
    output logic [CHW-1:0]    rom_char_o,
    output logic [COLW-1:0]   rom_col_o,
    output logic              pass_o
);
    localparam logic [COLW-1:0] COL_LAST = COLW'(ROM_COLS - 1);

    typedef struct packed {
        logic [CHW-1:0]    chr;
        logic [COLW-1:0]   col;
        logic              valid;
        logic [DATA_W-1:0] sum;
    } scan_t;

    scan_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = rom_phase_i;
        if (rom_phase_i) begin
            if (s_q.col == COL_LAST) begin
                s_d.col = '0;
                s_d.chr = s_q.chr + 1'b1;
            end else begin
                s_d.col = s_q.col + 1'b1;
            end
        end else begin
            s_d.chr = '0;
            s_d.col = '0;
        end
        if (!busy_i)      s_d.sum = '0;
        else if (s_q.valid) s_d.sum = s_q.sum + rom_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rom_rd_o   = rom_phase_i;
    assign rom_char_o = s_q.chr;
    assign rom_col_o  = s_q.col;
    assign pass_o     = (s_q.sum == EXP_SUM);

    AST_ROM_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_o |-> busy_i); // R4
    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_o |-> s_q.col <= COL_LAST); // R4
    AST_SCAN_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_rd_o) |-> s_q.chr == '0 && s_q.col == '0); // R4
endmodule

// File: rtl/fst_pattern.sv
module fst_pattern
    import fst_pkg::*;
#(
    parameter int SCAN_W = 3
) (
    input  pat_mode_e         mode_i,
    input  logic [SCAN_W-1:0] scan_row_i,
    input  logic [SCAN_W-1:0] scan_col_i,
    output logic              pat_en_o,
    output logic              pat_pixel_o
);
    logic [SCAN_W:0] pos_sum;
    logic            even;

    always_comb begin
        pos_sum     = {1'b0, scan_row_i} + {1'b0, scan_col_i};
        even        = ((pos_sum % (SCAN_W+1)'(2)) == '0);
        pat_en_o    = (mode_i != PAT_OFF);
        pat_pixel_o = 1'b0;
        if (mode_i == PAT_CHECK)       pat_pixel_o = even;
        else if (mode_i == PAT_INVERT) pat_pixel_o = !even;
    end
endmodule

// File: rtl/fst_restore.sv
module fst_restore
    import fst_pkg::*;
#(
    parameter int DIGITS     = 8,
    parameter int DATA_W     = 8,
    parameter int GLYPH_W    = 4,
    parameter logic [DATA_W-1:0] BLANK = 8'h20,
    parameter int RESULT_BIT = 5,
    localparam int DAW = $clog2(DIGITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              pass_i,
    output logic              wr_en_o,
    output wr_tgt_e           wr_tgt_o,
    output logic [DAW-1:0]    wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam logic [DAW-1:0] SLOT_LAST = DAW'(DIGITS - 1);

    typedef struct packed {
        logic           active;
        wr_tgt_e        tgt;
        logic [DAW-1:0] slot;
    } rst_seq_t;

    rst_seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (go_i) begin
            s_d.active = 1'b1;
            s_d.tgt    = TGT_CHAR;
            s_d.slot   = '0;
        end else if (s_q.active) begin
            case (s_q.tgt)
                TGT_CHAR, TGT_FLASH: begin
                    if (s_q.slot == SLOT_LAST) begin
                        s_d.slot = '0;
                        s_d.tgt  = (s_q.tgt == TGT_CHAR) ? TGT_FLASH : TGT_GLYPH;
                    end else begin
                        s_d.slot = s_q.slot + 1'b1;
                    end
                end
                TGT_GLYPH: s_d.tgt = TGT_CTRL;
                default: begin
                    s_d.active = 1'b0;
                    s_d.tgt    = TGT_CHAR;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        wr_en_o   = s_q.active;
        wr_tgt_o  = s_q.tgt;
        wr_addr_o = '0;
        wr_data_o = '0;
        case (s_q.tgt)
            TGT_CHAR: begin
                wr_addr_o = s_q.slot;
                wr_data_o = BLANK;
            end
            TGT_FLASH: wr_addr_o = s_q.slot;
            TGT_GLYPH: wr_data_o = DATA_W'({GLYPH_W{1'b1}});
            default:   wr_data_o[RESULT_BIT] = pass_i;
        endcase
    end

    AST_CTRL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active && s_q.tgt == TGT_CTRL |=> !s_q.active); // R8
    AST_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !s_q.active); // R8
endmodule

// File: rtl/fst_selftest.sv
module fst_selftest
    import fst_pkg::*;
#(
    parameter int TOTAL_CLKS = 262144,
    parameter int PAT_CLKS   = 65536,
    parameter int ROM_CHARS  = 128,
    parameter int ROM_COLS   = 5,
    parameter int DIGITS     = 8,
    parameter int SCAN_W     = 3,
    parameter int GLYPH_W    = 4,
    parameter logic [7:0] BLANK   = 8'h20,
    parameter logic [7:0] EXP_SUM = 8'h00,
    localparam int CHW  = $clog2(ROM_CHARS),
    localparam int COLW = $clog2(ROM_COLS),
    localparam int DAW  = $clog2(DIGITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              rom_rd_o,
    output logic [CHW-1:0]    rom_char_o,
    output logic [COLW-1:0]   rom_col_o,
    input  logic [7:0]        rom_data_i,
    input  logic [SCAN_W-1:0] scan_row_i,
    input  logic [SCAN_W-1:0] scan_col_i,
    output logic              pat_en_o,
    output logic              pat_pixel_o,
    output logic              wr_en_o,
    output logic [1:0]        wr_tgt_o,
    output logic [DAW-1:0]    wr_addr_o,
    output logic [7:0]        wr_data_o
);
    localparam int ROM_SPAN    = ROM_CHARS * ROM_COLS;
    localparam int RESTORE_LEN = 2 * DIGITS + 2;

    logic      rom_phase;
    logic      rest_go;
    logic      pass;
    pat_mode_e pat_mode;
    wr_tgt_e   tgt;

    fst_timer #(
        .TOTAL_CLKS (TOTAL_CLKS),
        .ROM_SPAN   (ROM_SPAN),
        .PAT_CLKS   (PAT_CLKS),
        .RESTORE_LEN(RESTORE_LEN)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .busy_o     (busy_o),
        .rom_phase_o(rom_phase),
        .pat_mode_o (pat_mode),
        .rest_go_o  (rest_go)
    );

    fst_rom_scan #(
        .ROM_CHARS(ROM_CHARS),
        .ROM_COLS (ROM_COLS),
        .DATA_W   (8),
        .EXP_SUM  (EXP_SUM)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_o),
        .rom_phase_i(rom_phase),
        .rom_data_i (rom_data_i),
        .rom_rd_o   (rom_rd_o),
        .rom_char_o (rom_char_o),
        .rom_col_o  (rom_col_o),
        .pass_o     (pass)
    );

    fst_pattern #(
        .SCAN_W(SCAN_W)
    ) u_pattern (
        .mode_i     (pat_mode),
        .scan_row_i (scan_row_i),
        .scan_col_i (scan_col_i),
        .pat_en_o   (pat_en_o),
        .pat_pixel_o(pat_pixel_o)
    );

    fst_restore #(
        .DIGITS    (DIGITS),
        .DATA_W    (8),
        .GLYPH_W   (GLYPH_W),
        .BLANK     (BLANK),
        .RESULT_BIT(5)
    ) u_restore (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (rest_go),
        .pass_i   (pass),
        .wr_en_o  (wr_en_o),
        .wr_tgt_o (tgt),
        .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o)
    );

    assign wr_tgt_o = tgt;

    AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && (pat_en_o || rom_rd_o))); // R10
    AST_PIX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !pat_en_o |-> !pat_pixel_o); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_en_o && !pat_en_o && !rom_rd_o); // R1
endmodule

// File: tb/fst_selftest_test.sv
module fst_selftest_test;
    localparam int TOTAL = 1024;
    localparam int PAT   = 128;
    localparam int CHARS = 128;
    localparam int COLS  = 5;
    localparam int DIG   = 8;
    localparam int SW    = 3;
    localparam int GW    = 4;
    localparam int RLEN  = 2 * DIG + 2;
    localparam int PSTART = TOTAL - 2 * PAT - RLEN;
    localparam int WSTART = TOTAL - RLEN;

    function automatic logic [7:0] rom_byte(int c, int k, bit bad);
        int v;
        v = (c * 37 + k * 11 + ((c ^ k) * 3)) % 256;
        if (bad && c == 65 && k == 2) v = v ^ 1;
        return 8'(v);
    endfunction

    function automatic logic [7:0] rom_sum(bit bad);
        int s;
        s = 0;
        for (int c = 0; c < CHARS; c++)
            for (int k = 0; k < COLS; k++)
                s = (s + int'(rom_byte(c, k, bad))) % 256;
        return 8'(s);
    endfunction

    localparam logic [7:0] GOOD_SUM = rom_sum(1'b0);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    bit   corrupt = 1'b0;
    logic busy, rom_rd, pat_en, pat_pixel, wr_en;
    logic [6:0] rom_char;
    logic [2:0] rom_col;
    logic [7:0] rom_q = 8'h00;
    logic [SW-1:0] scan_row = '0;
    logic [SW-1:0] scan_col = '0;
    logic [1:0] wr_tgt;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fst_selftest #(
        .TOTAL_CLKS(TOTAL), .PAT_CLKS(PAT), .ROM_CHARS(CHARS), .ROM_COLS(COLS),
        .DIGITS(DIG), .SCAN_W(SW), .GLYPH_W(GW), .BLANK(8'h20), .EXP_SUM(GOOD_SUM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
        .rom_rd_o(rom_rd), .rom_char_o(rom_char), .rom_col_o(rom_col),
        .rom_data_i(rom_q), .scan_row_i(scan_row), .scan_col_i(scan_col),
        .pat_en_o(pat_en), .pat_pixel_o(pat_pixel), .wr_en_o(wr_en),
        .wr_tgt_o(wr_tgt), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    // ROM with one cycle of read latency
    always @(posedge clk) rom_q <= rom_byte(int'(rom_char), int'(rom_col), corrupt);

    // scanner coordinates move just after each rising edge
    initial begin
        int t;
        t = 0;
        forever begin
            @(posedge clk);
            #1;
            t++;
            scan_row = SW'(t % 7);
            scan_col = SW'((t / 3) % 5);
        end
    end

    // behavioural reference timeline
    int m_busy = 0;
    int m_cnt  = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0;
            m_cnt  = 0;
        end else if (m_busy == 0) begin
            if (start) begin
                m_busy = 1;
                m_cnt  = 0;
            end
        end else if (m_cnt == TOTAL - 1) begin
            m_busy = 0;
        end else begin
            m_cnt++;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit b, in_rom, in_chk, in_inv, in_wr, even, pass;
            int i;
            b      = (m_busy != 0);
            in_rom = b && m_cnt < CHARS * COLS;
            in_chk = b && m_cnt >= PSTART && m_cnt < PSTART + PAT;
            in_inv = b && m_cnt >= PSTART + PAT && m_cnt < WSTART;
            in_wr  = b && m_cnt >= WSTART;
            even   = ((int'(scan_row) + int'(scan_col)) % 2) == 0;
            pass   = (rom_sum(corrupt) == GOOD_SUM);

            chk((b && start) ? "R3 busy held" : "R2 busy", int'(busy), int'(b));
            chk(in_rom ? "R4 rom_rd" : "R10 rom_rd idle", int'(rom_rd), int'(in_rom));
            if (in_rom && rom_rd) begin
                chk("R4 glyph index", int'(rom_char), m_cnt / COLS);
                chk("R4 column index", int'(rom_col), m_cnt % COLS);
            end
            if (in_chk) begin
                chk("R6 pat_en", int'(pat_en), 1);
                chk("R6 checker pixel", int'(pat_pixel), int'(even));
            end else if (in_inv) begin
                chk("R7 pat_en", int'(pat_en), 1);
                chk("R7 inverse pixel", int'(pat_pixel), int'(!even));
            end else begin
                chk("R10 pat_en off", int'(pat_en), 0);
                chk("R10 pixel off", int'(pat_pixel), 0);
            end
            chk(in_wr ? "R8 wr_en" : "R10 wr_en off", int'(wr_en), int'(in_wr));
            if (in_wr && wr_en) begin
                i = m_cnt - WSTART;
                if (i < DIG) begin
                    chk("R8 char tgt", int'(wr_tgt), 0);
                    chk("R8 char addr", int'(wr_addr), i);
                    chk("R8 char blank", int'(wr_data), 'h20);
                end else if (i < 2 * DIG) begin
                    chk("R8 flash tgt", int'(wr_tgt), 1);
                    chk("R8 flash addr", int'(wr_addr), i - DIG);
                    chk("R8 flash data", int'(wr_data), 0);
                end else if (i == 2 * DIG) begin
                    chk("R8 glyph tgt", int'(wr_tgt), 2);
                    chk("R8 glyph data", int'(wr_data), (1 << GW) - 1);
                end else begin
                    chk("R8 ctrl tgt", int'(wr_tgt), 3);
                    chk("R5 R9 ctrl result", int'(wr_data), pass ? 'h20 : 0);
                end
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs quiet under reset
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 wr_en in reset", int'(wr_en), 0);
        chk("R1 pat_en in reset", int'(pat_en), 0);
        chk("R1 rom_rd in reset", int'(rom_rd), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", int'(busy | wr_en | pat_en | pat_pixel | rom_rd), 0);

        // run 1: good ROM, extra start pulse mid-run (R3)
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (TOTAL) @(negedge clk);

        // run 2: one ROM byte differs, so the result is fail (R5)
        corrupt = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (TOTAL + 20) @(negedge clk);

        // run 3: start held through a whole routine, restarts right after (R3)
        corrupt = 1'b0;
        start = 1'b1;
        repeat (TOTAL + 3) @(negedge clk);
        start = 1'b0;
        repeat (TOTAL + 20) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule